// File: doc/BRIEF.md
# System Control Register File

This block holds the small set of control, status and identification registers that a processor core reads and writes through a coprocessor-style register index. It keeps a processor status word, a system control word, a floating-point status word, a floating-point exception word, a coprocessor access word and an event mailbox flag. Next to these sit five read-only identification words. One pseudo-index splits its write data into two fields of the status word.

Each index has its own write rule. A write can be a plain store, a masked merge with the old value, a store that keeps one protected bit, a store that forces some bits to zero, or a dropped write. The reset values come partly from a three-bit boot configuration input, which is sampled while reset is held. When the status word is read, two of its bits come live from the program-counter state input instead of from storage. The port takes one request per cycle and answers in the following cycle. Any index inside the unimplemented window answers with a one-cycle error and has no other effect.

A small response state machine tracks what the previous cycle's request was. It has four states:
- RSP_NONE: no request was made.
- RSP_READ: an implemented read was made.
- RSP_WRITE: an implemented write was made.
- RSP_FAULT: an unimplemented index was accessed.

Every clock edge moves the machine to the state that the current request selects:
- a request to an index inside the window goes to RSP_FAULT;
- a write elsewhere goes to RSP_WRITE;
- a read elsewhere goes to RSP_READ;
- no request goes to RSP_NONE.

Reset forces RSP_NONE.

Top module: `sysctl_regfile`

## Requirements
- R1: While reset is held and after it is released, the status word (index 0) reads 0x0000_0010 (user mode in bits 4:0) with pc_state at zero. The floating-point status (index 2), exception (index 3) and access (index 4) words read zero, the mailbox (index 11) reads 1 and the TLB type word (index 6) reads 1.
- R2: Reset loads the control word (index 1) with 0x00C0_0070 ORed with the boot configuration: cfg_boot[0] goes to bit 13, cfg_boot[1] to bit 25 and cfg_boot[2] to bit 27.
- R3: A write to the control word stores every bit of the write data except bit 27, which keeps its previous value.
- R4: Writes to indices 6 to 10 are dropped. These indices always read their fixed values: 0x1 (6), 0x1011_1222 (7), 0x1111_1111 (8), 0x0 (9) and 0x0003_30A1 (10).
- R5: A write to the exception word (index 3) changes only bits 30:29; all other bits keep their old value.
- R6: A write to the access word (index 4) keeps write-data bits 31 and 23:20 and stores zero in all other bits.
- R7: A write to the floating-point status word (index 2) stores (wdata AND mask) OR (old AND NOT mask), where the mask defaults to 0xFFF7_009F.
- R8: A write to index 5 places wdata[1:0] in status bits 26:25 and wdata[7:2] in status bits 15:10, leaving the other status bits alone. A read of index 5 returns zero.
- R9: A read of the status word returns pc_state[1] in bit 24 and pc_state[0] in bit 5, whatever the stored bits hold.
- R10: A read or write to an index from 12 to 15 sets rsp_err for exactly the next cycle, returns zero read data and changes no register.
- R11: rsp_valid is high in the cycle after every request and low in the cycle after a cycle with no request. A write response carries zero read data.
- R12: A write to the mailbox (index 11) stores wdata[0]. A read returns that bit zero-extended.
- R13: A write to the status word (index 0) stores all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_boot | input | 3 | Boot configuration: [0] high vectors, [1] exception endianness, [2] non-maskable fast interrupt |
| pc_state | input | 2 | Program-counter state flags: [1] J, [0] T |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | IDX_W | Register index |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Previous request hit the unimplemented window |
| rsp_rdata | output | 32 | Read data of the previous request |

## Verification
The hardest case to reach is the protected bit 27 of the control word. No write can set or clear it, so only reset can change it. The stimulus therefore applies reset twice: once with the configuration bit high, then writes all zeros to prove the bit stays one, and once with it low, then writes all ones to prove it stays zero. The live J/T substitution is reached by first storing all ones in the status word and then reading with different pc_state values, so that stored and substituted bits disagree.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DATA_W = 32;

    // register index assignment
    localparam int IX_STAT  = 0;
    localparam int IX_CTRL  = 1;
    localparam int IX_FPST  = 2;
    localparam int IX_FPEX  = 3;
    localparam int IX_CPAC  = 4;
    localparam int IX_ITSPL = 5;
    localparam int IX_TLBT  = 6;
    localparam int IX_MED0  = 7;
    localparam int IX_MED1  = 8;
    localparam int IX_MPID  = 9;
    localparam int IX_FPID  = 10;
    localparam int IX_MBOX  = 11;

    // status word fields decoded by neighbouring logic
    localparam int          ST_JBIT     = 24;
    localparam int          ST_TBIT     = 5;
    localparam logic [4:0]  ST_MODE_USR = 5'b10000;

    // control word fields
    localparam int                 CT_NMFI  = 27;
    localparam int                 CT_EE    = 25;
    localparam int                 CT_HIVEC = 13;
    localparam logic [DATA_W-1:0]  CT_FIXED = 32'h00C0_0070;

    typedef enum logic [1:0] {
        RSP_NONE,
        RSP_READ,
        RSP_WRITE,
        RSP_FAULT
    } rsp_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] stat;
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] fpst;
        logic [DATA_W-1:0] fpex;
        logic [DATA_W-1:0] cpac;
        logic              mbox;
    } ctl_regs_t;

endpackage

// File: rtl/sysctl_access_fsm.sv
module sysctl_access_fsm
    import sysctl_pkg::*;
#(
    parameter int IDX_W    = 4,
    parameter int UNIMP_LO = 12,
    parameter int UNIMP_HI = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [IDX_W-1:0] req_index,
    output logic             fault_hit,
    output logic             acc_rd,
    output logic             acc_wr,
    output logic             rsp_valid,
    output logic             rsp_err
);

    rsp_state_e state_q, state_d;
    logic       in_window;

    always_comb begin
        in_window = (int'(req_index) >= UNIMP_LO) && (int'(req_index) <= UNIMP_HI);
        fault_hit = req_valid && in_window;
        acc_wr    = req_valid && !in_window && req_write;
        acc_rd    = req_valid && !in_window && !req_write;
    end

    always_comb begin
        if (fault_hit)   state_d = RSP_FAULT;
        else if (acc_wr) state_d = RSP_WRITE;
        else if (acc_rd) state_d = RSP_READ;
        else             state_d = RSP_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RSP_NONE;
        else        state_q <= state_d;
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        unique case (state_q)
            RSP_NONE:  ;
            RSP_READ:  rsp_valid = 1'b1;
            RSP_WRITE: rsp_valid = 1'b1;
            RSP_FAULT: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
            end
            default:   ;
        endcase
    end

    // R10: a hit on the unimplemented window answers with an error next cycle
    a_r10_fault_answers: assert property (@(posedge clk) disable iff (!rst_n)
        fault_hit |=> rsp_err);

    // R10: error lasts a single cycle unless a new fault request arrives
    a_r10_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_err && !fault_hit) |=> !rsp_err);

    // R11: every request gets a response the following cycle
    a_r11_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R11: no request, no response
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

endmodule

// File: rtl/sysctl_wr_merge.sv
module sysctl_wr_merge
    import sysctl_pkg::*;
#(
    parameter int                IDX_W     = 4,
    parameter logic [DATA_W-1:0] FPST_MASK = 32'hFFF7_009F,
    parameter logic [DATA_W-1:0] FPEX_MASK = 32'h6000_0000,
    parameter logic [DATA_W-1:0] CPAC_KEEP = 32'h80F0_0000
) (
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  ctl_regs_t         cur,
    output ctl_regs_t         nxt
);

    always_comb begin
        nxt = cur;
        if (wr_en) begin
            case (int'(idx))
                IX_STAT: nxt.stat = wdata;
                IX_CTRL: begin
                    nxt.ctrl          = wdata;
                    nxt.ctrl[CT_NMFI] = cur.ctrl[CT_NMFI];
                end
                IX_FPST: nxt.fpst = (wdata & FPST_MASK) | (cur.fpst & ~FPST_MASK);
                IX_FPEX: nxt.fpex = (wdata & FPEX_MASK) | (cur.fpex & ~FPEX_MASK);
                IX_CPAC: nxt.cpac = wdata & CPAC_KEEP;
                IX_ITSPL: begin
                    nxt.stat[26:25] = wdata[1:0];
                    nxt.stat[15:10] = wdata[7:2];
                end
                IX_MBOX: nxt.mbox = wdata[0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sysctl_rd_mux.sv
module sysctl_rd_mux
    import sysctl_pkg::*;
#(
    parameter int                IDX_W   = 4,
    parameter logic [DATA_W-1:0] ID_TLBT = 32'h0000_0001,
    parameter logic [DATA_W-1:0] ID_MED0 = 32'h1011_1222,
    parameter logic [DATA_W-1:0] ID_MED1 = 32'h1111_1111,
    parameter logic [DATA_W-1:0] ID_MPID = 32'h0000_0000,
    parameter logic [DATA_W-1:0] ID_FPID = 32'h0003_30A1
) (
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [1:0]        pc_state,
    input  ctl_regs_t         cur,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (int'(idx))
                IX_STAT: begin
                    rdata          = cur.stat;
                    rdata[ST_JBIT] = pc_state[1];
                    rdata[ST_TBIT] = pc_state[0];
                end
                IX_CTRL: rdata = cur.ctrl;
                IX_FPST: rdata = cur.fpst;
                IX_FPEX: rdata = cur.fpex;
                IX_CPAC: rdata = cur.cpac;
                IX_TLBT: rdata = ID_TLBT;
                IX_MED0: rdata = ID_MED0;
                IX_MED1: rdata = ID_MED1;
                IX_MPID: rdata = ID_MPID;
                IX_FPID: rdata = ID_FPID;
                IX_MBOX: rdata = {{(DATA_W-1){1'b0}}, cur.mbox};
                default: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter int                IDX_W     = 4,
    parameter int                UNIMP_LO  = 12,
    parameter int                UNIMP_HI  = 15,
    parameter logic [DATA_W-1:0] FPST_MASK = 32'hFFF7_009F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_boot,
    input  logic [1:0]        pc_state,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [IDX_W-1:0]  req_index,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam logic [DATA_W-1:0] FPEX_MASK = 32'h6000_0000;
    localparam logic [DATA_W-1:0] CPAC_KEEP = 32'h80F0_0000;

    ctl_regs_t         regs_q, regs_d, regs_rst;
    logic              fault_hit, acc_rd, acc_wr;
    logic [DATA_W-1:0] rd_val, rdata_q;

    sysctl_access_fsm #(
        .IDX_W    (IDX_W),
        .UNIMP_LO (UNIMP_LO),
        .UNIMP_HI (UNIMP_HI)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_index (req_index),
        .fault_hit (fault_hit),
        .acc_rd    (acc_rd),
        .acc_wr    (acc_wr),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err)
    );

    sysctl_wr_merge #(
        .IDX_W     (IDX_W),
        .FPST_MASK (FPST_MASK),
        .FPEX_MASK (FPEX_MASK),
        .CPAC_KEEP (CPAC_KEEP)
    ) u_merge (
        .wr_en (acc_wr),
        .idx   (req_index),
        .wdata (req_wdata),
        .cur   (regs_q),
        .nxt   (regs_d)
    );

    sysctl_rd_mux #(
        .IDX_W (IDX_W)
    ) u_rdmux (
        .rd_en    (acc_rd),
        .idx      (req_index),
        .pc_state (pc_state),
        .cur      (regs_q),
        .rdata    (rd_val)
    );

    always_comb begin
        regs_rst               = '0;
        regs_rst.stat[4:0]     = ST_MODE_USR;
        regs_rst.ctrl          = CT_FIXED;
        regs_rst.ctrl[CT_HIVEC] = cfg_boot[0];
        regs_rst.ctrl[CT_EE]   = cfg_boot[1];
        regs_rst.ctrl[CT_NMFI] = cfg_boot[2];
        regs_rst.mbox          = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q  <= regs_rst;
            rdata_q <= '0;
        end else begin
            regs_q  <= regs_d;
            rdata_q <= rd_val;
        end
    end

    assign rsp_rdata = rdata_q;

    // R3: the protected control bit only changes under reset
    a_r3_nmfi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(regs_q.ctrl[CT_NMFI]));

    // R5: exception word bits outside 30:29 never move after reset
    a_r5_fpex_rest_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(regs_q.fpex[28:0]) && $stable(regs_q.fpex[31])));

    // R6: access word holds nothing outside its kept fields
    a_r6_cpac_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((regs_q.cpac & ~CPAC_KEEP) == '0));

    // R10: an unimplemented access leaves every register untouched
    a_r10_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fault_hit)) |-> (regs_q == $past(regs_q)));

    // R11: responses other than reads carry zero data
    a_r11_write_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr || fault_hit) |=> (rsp_rdata == '0));

endmodule

// File: tb/sysctl_regfile_test.sv
module sysctl_regfile_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 48;

    typedef struct packed {
        logic        wr;
        logic [3:0]  idx;
        logic [31:0] wd;
        logic [1:0]  pc;
        logic [31:0] exp;
        logic        err;
        logic [7:0]  req;
    } vec_t;

    // rows assume reset with cfg_boot = 3'b101
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd1,  32'h0,        2'd0, 32'h08C0_2070, 1'b0, 8'd2},  // R2 reset ctrl
        '{1'b1, 4'd1,  32'h0,        2'd0, 32'h0,         1'b0, 8'd3},  // R3
        '{1'b0, 4'd1,  32'h0,        2'd0, 32'h0800_0000, 1'b0, 8'd3},  // R3 bit 27 kept
        '{1'b1, 4'd1,  32'h0000_1234, 2'd0, 32'h0,        1'b0, 8'd3},
        '{1'b0, 4'd1,  32'h0,        2'd0, 32'h0800_1234, 1'b0, 8'd3},
        '{1'b0, 4'd0,  32'h0,        2'd0, 32'h0000_0010, 1'b0, 8'd1},  // R1 status reset
        '{1'b0, 4'd0,  32'h0,        2'd3, 32'h0100_0030, 1'b0, 8'd9},  // R9 J,T live
        '{1'b0, 4'd0,  32'h0,        2'd2, 32'h0100_0010, 1'b0, 8'd9},
        '{1'b1, 4'd5,  32'h0000_00FF, 2'd0, 32'h0,        1'b0, 8'd8},  // R8 split
        '{1'b0, 4'd0,  32'h0,        2'd0, 32'h0600_FC10, 1'b0, 8'd8},
        '{1'b1, 4'd5,  32'h0000_0001, 2'd0, 32'h0,        1'b0, 8'd8},
        '{1'b0, 4'd0,  32'h0,        2'd0, 32'h0200_0010, 1'b0, 8'd8},
        '{1'b0, 4'd5,  32'h0,        2'd0, 32'h0,         1'b0, 8'd8},
        '{1'b1, 4'd0,  32'hFFFF_FFFF, 2'd0, 32'h0,        1'b0, 8'd13}, // R13
        '{1'b0, 4'd0,  32'h0,        2'd0, 32'hFEFF_FFDF, 1'b0, 8'd13},
        '{1'b0, 4'd0,  32'h0,        2'd3, 32'hFFFF_FFFF, 1'b0, 8'd13},
        '{1'b0, 4'd3,  32'h0,        2'd0, 32'h0,         1'b0, 8'd1},
        '{1'b1, 4'd3,  32'hFFFF_FFFF, 2'd0, 32'h0,        1'b0, 8'd5},  // R5
        '{1'b0, 4'd3,  32'h0,        2'd0, 32'h6000_0000, 1'b0, 8'd5},
        '{1'b1, 4'd3,  32'h2000_0001, 2'd0, 32'h0,        1'b0, 8'd5},
        '{1'b0, 4'd3,  32'h0,        2'd0, 32'h2000_0000, 1'b0, 8'd5},
        '{1'b1, 4'd4,  32'hFFFF_FFFF, 2'd0, 32'h0,        1'b0, 8'd6},  // R6
        '{1'b0, 4'd4,  32'h0,        2'd0, 32'h80F0_0000, 1'b0, 8'd6},
        '{1'b1, 4'd4,  32'h0030_0000, 2'd0, 32'h0,        1'b0, 8'd6},
        '{1'b0, 4'd4,  32'h0,        2'd0, 32'h0030_0000, 1'b0, 8'd6},
        '{1'b1, 4'd2,  32'hFFFF_FFFF, 2'd0, 32'h0,        1'b0, 8'd7},  // R7
        '{1'b0, 4'd2,  32'h0,        2'd0, 32'hFFF7_009F, 1'b0, 8'd7},
        '{1'b1, 4'd2,  32'h0000_0108, 2'd0, 32'h0,        1'b0, 8'd7},
        '{1'b0, 4'd2,  32'h0,        2'd0, 32'h0000_0008, 1'b0, 8'd7},
        '{1'b0, 4'd6,  32'h0,        2'd0, 32'h0000_0001, 1'b0, 8'd4},  // R4
        '{1'b1, 4'd6,  32'h0000_DEAD, 2'd0, 32'h0,        1'b0, 8'd4},
        '{1'b0, 4'd6,  32'h0,        2'd0, 32'h0000_0001, 1'b0, 8'd4},
        '{1'b1, 4'd9,  32'h0000_FFFF, 2'd0, 32'h0,        1'b0, 8'd4},
        '{1'b0, 4'd9,  32'h0,        2'd0, 32'h0,         1'b0, 8'd4},
        '{1'b1, 4'd10, 32'h0,        2'd0, 32'h0,         1'b0, 8'd4},
        '{1'b0, 4'd10, 32'h0,        2'd0, 32'h0003_30A1, 1'b0, 8'd4},
        '{1'b0, 4'd7,  32'h0,        2'd0, 32'h1011_1222, 1'b0, 8'd4},
        '{1'b0, 4'd8,  32'h0,        2'd0, 32'h1111_1111, 1'b0, 8'd4},
        '{1'b0, 4'd11, 32'h0,        2'd0, 32'h0000_0001, 1'b0, 8'd12}, // R12
        '{1'b1, 4'd11, 32'hFFFF_FFFE, 2'd0, 32'h0,        1'b0, 8'd12},
        '{1'b0, 4'd11, 32'h0,        2'd0, 32'h0,         1'b0, 8'd12},
        '{1'b1, 4'd11, 32'h0000_0003, 2'd0, 32'h0,        1'b0, 8'd12},
        '{1'b0, 4'd11, 32'h0,        2'd0, 32'h0000_0001, 1'b0, 8'd12},
        '{1'b1, 4'd13, 32'h0000_1234, 2'd0, 32'h0,        1'b1, 8'd10}, // R10
        '{1'b0, 4'd14, 32'h0,        2'd0, 32'h0,         1'b1, 8'd10},
        '{1'b0, 4'd12, 32'h0,        2'd0, 32'h0,         1'b1, 8'd10},
        '{1'b1, 4'd15, 32'hFFFF_FFFF, 2'd0, 32'h0,        1'b1, 8'd10},
        '{1'b0, 4'd1,  32'h0,        2'd0, 32'h0800_1234, 1'b0, 8'd10}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  cfg_boot;
    logic [1:0]  pc_state;
    logic        req_valid, req_write;
    logic [3:0]  req_index;
    logic [31:0] req_wdata;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysctl_regfile uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_boot  (cfg_boot),
        .pc_state  (pc_state),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_index (req_index),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata)
    );

    task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one request presented at a falling edge, response sampled at the next falling edge
    task automatic access(input logic wr, input logic [3:0] idx, input logic [31:0] wd,
                          input logic [1:0] pc, input logic [31:0] exp, input logic err,
                          input string tag);
        req_valid = 1'b1;
        req_write = wr;
        req_index = idx;
        req_wdata = wd;
        pc_state  = pc;
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, {rsp_valid, rsp_err, rsp_rdata}, {1'b1, err, exp});
    endtask

    task automatic do_reset(input logic [2:0] cfg);
        req_valid = 1'b0;
        req_write = 1'b0;
        req_index = '0;
        req_wdata = '0;
        pc_state  = 2'd0;
        cfg_boot  = cfg;
        rst_n     = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset(3'b101);
        // R11 reset state of the response port
        check("R11 reset quiet", {rsp_valid, rsp_err, rsp_rdata}, 34'h0);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].idx, VECS[i].wd, VECS[i].pc, VECS[i].exp, VECS[i].err,
                   $sformatf("R%0d row %0d", VECS[i].req, i));
        end

        // R10 error lasts one cycle; R11 idle cycle gives no response
        access(1'b0, 4'd12, 32'h0, 2'd0, 32'h0, 1'b1, "R10 fault before idle");
        @(negedge clk);
        check("R10 R11 idle after fault", {rsp_valid, rsp_err, rsp_rdata}, 34'h0);

        // R2 second reset with other configuration; R3 protected bit stays low
        do_reset(3'b010);
        access(1'b0, 4'd1, 32'h0, 2'd0, 32'h02C0_0070, 1'b0, "R2 ctrl cfg 010");
        access(1'b1, 4'd1, 32'hFFFF_FFFF, 2'd0, 32'h0, 1'b0, "R3 write ones");
        access(1'b0, 4'd1, 32'h0, 2'd0, 32'hF7FF_FFFF, 1'b0, "R3 bit27 stays low");
        access(1'b0, 4'd0, 32'h0, 2'd0, 32'h0000_0010, 1'b0, "R1 status after reset");
        access(1'b0, 4'd2, 32'h0, 2'd0, 32'h0, 1'b0, "R1 fpst after reset");
        access(1'b0, 4'd4, 32'h0, 2'd0, 32'h0, 1'b0, "R1 cpac after reset");
        access(1'b0, 4'd11, 32'h0, 2'd0, 32'h1, 1'b0, "R1 mailbox after reset");
        access(1'b0, 4'd6, 32'h0, 2'd0, 32'h1, 1'b0, "R1 tlb type after reset");

        $display("  test done: total=%0d bad=%0d", total, bad);
        done = 1'b1;
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule